// File: doc/BRIEF.md
# VGA Timing and Test Pattern Generator

This block produces 640x480 video timing from a 25 MHz pixel clock. It also produces a colour test pattern and outputs it as three 8-bit channel values for external digital-to-analog converters. Two further outputs carry horizontal and vertical blank flags. An 8-bit packed port carries active-low HSYNC and VSYNC together with the top two bits of each colour channel.

The 8-bit input bus selects the pattern. The block captures it on every clock edge while reset is held low, and freezes it once reset is released. The selectable patterns are:
- a ramp: red follows the pixel column, green follows the line and blue follows the frame count;
- an XOR texture built from slices of the pixel and line counters;
- a pass-through mode, selected by an all-zero capture, in which the live input bus drives all three channels directly.

Every other captured value gives black colour with normal sync. All timing figures are parameters. The defaults are the standard 800x525 raster.

Top module: `vga_pattern_gen`

## Requirements
- R1: The mode register takes `mode_in` on every clock edge while `rst_n` is low, and does not change while `rst_n` is high. Later changes on `mode_in` affect the colours only in pass-through mode.
- R2: The column counter runs 0..H_VIS+H_FP+H_SYNC+H_BP-1 and the line counter runs 0..V_VIS+V_FP+V_SYNC+V_BP-1. `hblank_o` is 1 exactly when column >= H_VIS, and `vblank_o` is 1 exactly when line >= V_VIS.
- R3: HSYNC is low exactly for columns H_VIS+H_FP .. H_VIS+H_FP+H_SYNC-1. VSYNC is low exactly for lines V_VIS+V_FP .. V_VIS+V_FP+V_SYNC-1.
- R4: With mode 8'h10 in the active area, red = column[7:0] and green = line[7:0].
- R5: With mode 8'h10 in the active area, blue = an 8-bit frame count. The count starts at 0 after reset and increases by one on the clock where the line counter goes from V_VIS-1 to V_VIS. It wraps from 255 to 0.
- R6: With mode 8'h30 in the active area, red = col[7:0]^line[7:0], green = col[8:1]^line[7:0] and blue = col[7:0]^line[8:1].
- R7: With mode 8'h00, all three channels equal the live `mode_in`, whether or not blanking is active. An all-low input gives all-low channels.
- R8: In modes 8'h10 and 8'h30, all three channels are 0 while either blank flag is 1.
- R9: Any other captured mode gives 0 on all channels at all times.
- R10: `pack_out` bits 0 to 7 carry, in this order: red[7], green[7], blue[7], VSYNC, red[6], green[6], blue[6], HSYNC.
- R11: In the first cycle after reset release, the column and line are both 0. Both blank flags are then 0 and both syncs are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Synchronous reset, active low; mode captured while low |
| mode_in | input | 8 | Mode selector during reset, live data in pass-through |
| pack_out | output | 8 | Packed syncs and colour MSBs (R10) |
| red_o | output | 8 | Red channel value |
| grn_o | output | 8 | Green channel value |
| blu_o | output | 8 | Blue channel value |
| hblank_o | output | 1 | Horizontal blank flag |
| vblank_o | output | 1 | Vertical blank flag |

## Verification
The bench builds two instances with shrunken rasters.

The first uses 260/4/6/10 columns and 4/1/2/1 lines. Its lines are wide enough for the red ramp to reach full scale and wrap at column 256, and for column bit 8 to enter the XOR terms.

The second uses 20/2/3/3 columns and 6/1/2/1 lines. That gives a 280-cycle frame, so the blue frame count wraps past 255 within one ramp run.

// File: rtl/vga_pattern_gen.sv
module vga_pattern_gen #(
  parameter int H_VIS  = 640,
  parameter int H_FP   = 16,
  parameter int H_SYNC = 96,
  parameter int H_BP   = 48,
  parameter int V_VIS  = 480,
  parameter int V_FP   = 10,
  parameter int V_SYNC = 2,
  parameter int V_BP   = 33
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:0] mode_in,
  output logic [7:0] pack_out,
  output logic [7:0] red_o,
  output logic [7:0] grn_o,
  output logic [7:0] blu_o,
  output logic       hblank_o,
  output logic       vblank_o
);
  localparam int H_TOT = H_VIS + H_FP + H_SYNC + H_BP;
  localparam int V_TOT = V_VIS + V_FP + V_SYNC + V_BP;
  localparam int XW = $clog2(H_TOT);
  localparam int YW = $clog2(V_TOT);
  localparam logic [7:0] MODE_PASS = 8'h00;
  localparam logic [7:0] MODE_RAMP = 8'h10;
  localparam logic [7:0] MODE_XOR  = 8'h30;

  logic [XW-1:0] x_q;
  logic [YW-1:0] y_q;
  logic [7:0]    frame_q;
  logic [7:0]    mode_q;
  logic [31:0]   xs, ys;
  logic          line_end, active, hsync_n, vsync_n;

  assign xs       = 32'(x_q);
  assign ys       = 32'(y_q);
  assign line_end = xs == H_TOT - 1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q  <= mode_in;
      x_q     <= '0;
      y_q     <= '0;
      frame_q <= '0;
    end else begin
      x_q <= line_end ? '0 : x_q + 1'b1;
      if (line_end) begin
        y_q <= (ys == V_TOT - 1) ? '0 : y_q + 1'b1;
        if (ys == V_VIS - 1) frame_q <= frame_q + 8'd1;
      end
    end
  end

  assign hblank_o = xs >= H_VIS;
  assign vblank_o = ys >= V_VIS;
  assign active   = !hblank_o && !vblank_o;
  assign hsync_n  = !(xs >= H_VIS + H_FP && xs < H_VIS + H_FP + H_SYNC);
  assign vsync_n  = !(ys >= V_VIS + V_FP && ys < V_VIS + V_FP + V_SYNC);

  always_comb begin
    red_o = '0;
    grn_o = '0;
    blu_o = '0;
    case (mode_q)
      MODE_PASS: begin
        red_o = mode_in;
        grn_o = mode_in;
        blu_o = mode_in;
      end
      MODE_RAMP: if (active) begin
        red_o = xs[7:0];
        grn_o = ys[7:0];
        blu_o = frame_q;
      end
      MODE_XOR: if (active) begin
        red_o = xs[7:0] ^ ys[7:0];
        grn_o = xs[8:1] ^ ys[7:0];
        blu_o = xs[7:0] ^ ys[8:1];
      end
      default: ;
    endcase
  end

  assign pack_out = {hsync_n, blu_o[6], grn_o[6], red_o[6],
                     vsync_n, blu_o[7], grn_o[7], red_o[7]};
endmodule

module vga_pattern_gen_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [7:0] mode_in,
  input logic [7:0] mode_q,
  input logic [7:0] pack_out,
  input logic [7:0] red_o,
  input logic [7:0] grn_o,
  input logic [7:0] blu_o,
  input logic       hblank_o,
  input logic       vblank_o
);
  AST_MODE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    $stable(mode_q)); // R1
  AST_VB_AT_LINE_START: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(vblank_o) |-> !hblank_o && $past(hblank_o)); // R2
  AST_HSYNC_IN_HBLANK: assert property (@(posedge clk) disable iff (!rst_n)
    !pack_out[7] |-> hblank_o); // R3
  AST_VSYNC_IN_VBLANK: assert property (@(posedge clk) disable iff (!rst_n)
    !pack_out[3] |-> vblank_o); // R3
  AST_RAMP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == 8'h10 && !hblank_o && !vblank_o && $past(rst_n && !hblank_o && !vblank_o))
    |-> red_o == $past(red_o) + 8'd1); // R4
  AST_PASS_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
    mode_q == 8'h00 |-> red_o == mode_in && grn_o == mode_in && blu_o == mode_in); // R7
  AST_BLANK_BLACK: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q != 8'h00 && (hblank_o || vblank_o)) |-> (red_o | grn_o | blu_o) == 8'd0); // R8
  AST_OTHER_BLACK: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q != 8'h00 && mode_q != 8'h10 && mode_q != 8'h30) |-> (red_o | grn_o | blu_o) == 8'd0); // R9
endmodule

bind vga_pattern_gen vga_pattern_gen_chk u_chk (
  .clk(clk), .rst_n(rst_n), .mode_in(mode_in), .mode_q(mode_q),
  .pack_out(pack_out), .red_o(red_o), .grn_o(grn_o), .blu_o(blu_o),
  .hblank_o(hblank_o), .vblank_o(vblank_o)
);

// File: tb/vga_pattern_gen_tb.sv
module vga_pattern_gen_tb;
  localparam int AHV = 260, AHF = 4, AHS = 6, AHB = 10;
  localparam int AVV = 4,   AVF = 1, AVS = 2, AVB = 1;
  localparam int BHV = 20,  BHF = 2, BHS = 3, BHB = 3;
  localparam int BVV = 6,   BVF = 1, BVS = 2, BVB = 1;
  localparam int AHT = AHV + AHF + AHS + AHB, AVT = AVV + AVF + AVS + AVB;
  localparam int BHT = BHV + BHF + BHS + BHB, BVT = BVV + BVF + BVS + BVB;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic       rst_n = 1'b0;
  logic [7:0] mode_in = 8'h00;
  logic [7:0] a_pk, a_r, a_g, a_b, b_pk, b_r, b_g, b_b;
  logic       a_hb, a_vb, b_hb, b_vb;

  vga_pattern_gen #(.H_VIS(AHV), .H_FP(AHF), .H_SYNC(AHS), .H_BP(AHB),
                    .V_VIS(AVV), .V_FP(AVF), .V_SYNC(AVS), .V_BP(AVB)) u_dut (
    .clk(clk), .rst_n(rst_n), .mode_in(mode_in), .pack_out(a_pk),
    .red_o(a_r), .grn_o(a_g), .blu_o(a_b), .hblank_o(a_hb), .vblank_o(a_vb));

  vga_pattern_gen #(.H_VIS(BHV), .H_FP(BHF), .H_SYNC(BHS), .H_BP(BHB),
                    .V_VIS(BVV), .V_FP(BVF), .V_SYNC(BVS), .V_BP(BVB)) u_dut_small (
    .clk(clk), .rst_n(rst_n), .mode_in(mode_in), .pack_out(b_pk),
    .red_o(b_r), .grn_o(b_g), .blu_o(b_b), .hblank_o(b_hb), .vblank_o(b_vb));

  int checks = 0, errors = 0;
  int ax = 0, ay = 0, bx = 0, by = 0;
  logic [7:0] af = 8'd0, bf = 8'd0, mode_m = 8'h00;
  logic run_chk = 1'b0, done = 1'b0;

  always @(posedge clk) begin
    if (!rst_n) begin
      mode_m <= mode_in;
      ax <= 0; ay <= 0; af <= 8'd0;
      bx <= 0; by <= 0; bf <= 8'd0;
    end else begin
      ax <= (ax == AHT - 1) ? 0 : ax + 1;
      if (ax == AHT - 1) begin
        ay <= (ay == AVT - 1) ? 0 : ay + 1;
        if (ay == AVV - 1) af <= af + 8'd1;
      end
      bx <= (bx == BHT - 1) ? 0 : bx + 1;
      if (bx == BHT - 1) begin
        by <= (by == BVT - 1) ? 0 : by + 1;
        if (by == BVV - 1) bf <= bf + 8'd1;
      end
    end
  end

  function automatic logic [33:0] expect_px(int x, int y, logic [7:0] fr, logic [7:0] md,
      logic [7:0] live, int hv, int hf, int hs, int vv, int vf, int vs);
    logic hb, vb, hsn, vsn;
    logic [7:0] r, g, b;
    logic [8:0] xb, yb;
    xb = x[8:0];
    yb = y[8:0];
    hb = x >= hv;
    vb = y >= vv;
    hsn = !(x >= hv + hf && x < hv + hf + hs);
    vsn = !(y >= vv + vf && y < vv + vf + vs);
    r = 8'd0; g = 8'd0; b = 8'd0;
    if (md == 8'h00) begin
      r = live; g = live; b = live;
    end else if (!hb && !vb) begin
      if (md == 8'h10) begin
        r = xb[7:0]; g = yb[7:0]; b = fr;
      end else if (md == 8'h30) begin
        r = xb[7:0] ^ yb[7:0];
        g = xb[8:1] ^ yb[7:0];
        b = xb[7:0] ^ yb[8:1];
      end
    end
    return {r, g, b, hb, vb, hsn, b[6], g[6], r[6], vsn, b[7], g[7], r[7]};
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cmp(string nm, logic [33:0] e, logic [7:0] r, logic [7:0] g,
                     logic [7:0] b, logic hb, logic vb, logic [7:0] pk);
    string ct, bt;
    if (mode_m == 8'h00) ct = "R7 R1";
    else if (e[9] || e[8]) ct = (mode_m == 8'h10 || mode_m == 8'h30) ? "R8" : "R9";
    else if (mode_m == 8'h10) ct = "R4 R1";
    else if (mode_m == 8'h30) ct = "R6 R1";
    else ct = "R9";
    bt = (ct == "R4 R1") ? "R5" : ct;
    chk({nm, " ", ct, " red"}, 32'(r), 32'(e[33:26]));
    chk({nm, " ", ct, " green"}, 32'(g), 32'(e[25:18]));
    chk({nm, " ", bt, " blue"}, 32'(b), 32'(e[17:10]));
    chk({nm, " R2 blanks"}, 32'({hb, vb}), 32'(e[9:8]));
    chk({nm, " R3 syncs"}, 32'({pk[7], pk[3]}), 32'({e[7], e[3]}));
    chk({nm, " R10 packed colour bits"}, 32'({pk[6:4], pk[2:0]}), 32'({e[6:4], e[2:0]}));
  endtask

  always @(negedge clk) begin
    if (run_chk) begin
      cmp("A", expect_px(ax, ay, af, mode_m, mode_in, AHV, AHF, AHS, AVV, AVF, AVS),
          a_r, a_g, a_b, a_hb, a_vb, a_pk);
      cmp("B", expect_px(bx, by, bf, mode_m, mode_in, BHV, BHF, BHS, BVV, BVF, BVS),
          b_r, b_g, b_b, b_hb, b_vb, b_pk);
    end
  end

  task automatic run_mode(logic [7:0] m, int n);
    @(posedge clk); #1;
    rst_n = 1'b0;
    mode_in = m;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    mode_in = 8'($urandom);
    @(negedge clk); #1;
    chk("R11 blanks after reset", 32'({a_hb, a_vb, b_hb, b_vb}), 32'd0);
    chk("R11 syncs after reset", 32'({a_pk[7], a_pk[3], b_pk[7], b_pk[3]}), 32'hF);
    repeat (n) begin
      @(posedge clk); #1;
      mode_in = 8'($urandom);
    end
  endtask

  initial begin
    logic [7:0] odd;
    void'($urandom(32'd1234));
    repeat (2) @(posedge clk);
    run_chk = 1'b1;
    run_mode(8'h10, 72500);
    run_mode(8'h30, 3000);
    run_mode(8'h00, 1200);
    @(posedge clk); #1 mode_in = 8'h00;
    @(negedge clk); #1;
    chk("R7 all-low input gives low channels", 32'({a_r, a_g, a_b}), 32'd0);
    for (int i = 0; i < 3; i++) begin
      do odd = 8'($urandom); while (odd == 8'h00 || odd == 8'h10 || odd == 8'h30);
      run_mode(odd, 800);
    end
    run_mode(8'h30, 1500);
    run_chk = 1'b0;
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule